// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static RAM. Its 36-bit words are split into four 9-bit byte lanes. Reads and writes may follow one another on consecutive clocks with no idle cycle between them. Both directions use the same two-edge pipeline:

- A read registers its address on one edge and presents its word after the second enabled edge that follows.
- A write registers its address and byte mask on one edge and takes its data from the data bus two enabled edges later.

Because the two directions have the same latency, the data bus never has to turn around. Every control input is sampled on the rising clock edge.

On each selected cycle a load/advance input chooses between two actions. It either starts a new access at the external address, or continues the previous access type at the next address of a four-beat burst. The burst steps only the two low address bits. It runs in linear order or interleaved order, picked by a static mode pin.

A write is held in a one-entry buffer until the next write's data arrives, and only then is it stored in the array. Reads that hit the buffered address see its lanes merged over the stored word.

An active-low clock enable freezes the whole pipeline. A sleep input and an output enable both gate the output drivers without waiting for a clock. The full address is 19 bits wide. The array depth is a parameter (2^MEM_AW words), and only the low MEM_AW address bits index it.

Top module: `zt_sram`

## Requirements
- R1: A load cycle (adv_i = 0) selects the device only when sel_a_n_i = 0, sel_b_i = 1 and sel_c_n_i = 0. In any other combination, and on any advance cycle that follows such a deselected cycle, nothing is written and no read data is driven.
- R2: A read whose address is loaded on an enabled edge places the addressed word on dout_o, with dout_drv_o = 1, after the second enabled edge that follows. This assumes oe_n_i = 0 and sleep_i = 0.
- R3: A write (wr_n_i = 0) takes its data from wdata_i on the second enabled edge after its address edge. Writes and reads may alternate on every clock with no idle cycle, and each read returns the value left by all earlier writes.
- R4: lane_we_n_i[k] = 0 writes bits 9k+8 down to 9k of the word. Lanes whose bit is 1 keep their old contents, and an all-ones mask writes nothing.
- R5: With burst_lin_i = 1, each advance cycle (adv_i = 1) sets the two low address bits to (start + n) mod 4 for the n-th advance after the load. The upper bits keep the loaded address.
- R6: With burst_lin_i = 0, the n-th advance uses start XOR n in the two low address bits.
- R7: While clk_en_n_i = 1, edges are ignored. dout_o and dout_drv_o hold, no command or write data is taken, and pending operations resume unchanged once the clock enable returns low.
- R8: oe_n_i = 1 forces dout_drv_o to 0 and dout_o to zero at once, without a clock edge. Returning oe_n_i to 0 restores the held read word.
- R9: While sleep_i = 1, dout_drv_o is 0 at once, and every cycle is taken as deselected so that no write lands. Stored words survive.
- R10: A read of a word whose latest write is still buffered returns the buffered lanes merged over the stored word, including partial masks and back-to-back write-then-read.
- R11: After reset, dout_drv_o is 0 and no operation is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W (19) | Word address, sampled on load cycles |
| wdata_i | input | DW (36) | Write data, taken two enabled edges after the write address |
| sel_a_n_i | input | 1 | Chip select, active low |
| sel_b_i | input | 1 | Chip select, active high |
| sel_c_n_i | input | 1 | Chip select, active low |
| adv_i | input | 1 | 0 = load new address, 1 = advance burst |
| clk_en_n_i | input | 1 | Active-low clock enable; 1 freezes the pipeline |
| lane_we_n_i | input | LANES (4) | Active-low byte-lane write enables |
| wr_n_i | input | 1 | 0 = write, 1 = read |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| sleep_i | input | 1 | Power-down request, active high |
| burst_lin_i | input | 1 | Static burst order: 1 = linear, 0 = interleaved |
| dout_o | output | DW (36) | Read data, zero when not driven |
| dout_drv_o | output | 1 | High while dout_o is driven |

## Verification
The assertions check four things on every cycle:
- A deselected or sleeping cycle captures no command, and a frozen edge moves no pipeline stage and no output register.
- Each burst advance steps the low address bits in the selected order.
- A read reaches the output register two enabled edges after its address stage.
- A full-mask write followed at once by a read of the same word forwards the new data.

Only the bench's scenarios can show data integrity end to end. That covers full write and read sweeps, partial-lane writes merged through the write buffer, and reads of bursts checked against single-address accesses. It also covers writes suppressed by every bad chip-select combination or by sleep, a write whose data slot falls behind a freeze, and the immediate effect of the output enable and sleep on the drivers.

// File: rtl/zt_sram_pkg.sv
`timescale 1ns/1ps
package zt_sram_pkg;

  // Operation held in each pipeline stage.
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // Low two address bits for a burst beat.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       linear);
    return linear ? (start + beat) : (start ^ beat);
  endfunction

endpackage

// File: rtl/zt_sram_ctrl.sv
`timescale 1ns/1ps
// Command capture, burst address generation and two-stage pipeline.
module zt_sram_ctrl
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              sel_ok,
  input  logic              adv,
  input  logic              wr_n,
  input  logic              sleep,
  input  logic              linear,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_we_n,
  output op_e               a_op,
  output op_e               b_op,
  output logic [ADDR_W-1:0] b_addr,
  output logic [LANES-1:0]  b_mask
);

  logic [ADDR_W-1:0] a_addr;
  logic [LANES-1:0]  a_mask;
  logic [1:0]        start_q;
  logic [1:0]        beat_q;

  op_e               n_op;
  logic [ADDR_W-1:0] n_addr;
  logic [LANES-1:0]  n_mask;
  logic [1:0]        n_start;
  logic [1:0]        n_beat;

  // Next-state for stage A.
  always_comb begin
    n_op    = OP_IDLE;
    n_addr  = a_addr;
    n_start = start_q;
    n_beat  = beat_q;
    n_mask  = ~lane_we_n;
    if (!adv) begin
      n_addr  = addr;
      n_start = addr[1:0];
      n_beat  = 2'd0;
      if (sel_ok) begin
        n_op = wr_n ? OP_RD : OP_WR;
      end
    end else begin
      n_beat = beat_q + 2'd1;
      n_addr = {a_addr[ADDR_W-1:2], burst_low(start_q, beat_q + 2'd1, linear)};
      n_op   = a_op;
    end
    if (sleep) begin
      n_op    = OP_IDLE;
      n_addr  = a_addr;
      n_start = start_q;
      n_beat  = beat_q;
    end
  end

  // Pipeline registers, advanced only on enabled edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_op    <= OP_IDLE;
      a_addr  <= '0;
      a_mask  <= '0;
      start_q <= 2'd0;
      beat_q  <= 2'd0;
      b_op    <= OP_IDLE;
      b_addr  <= '0;
      b_mask  <= '0;
    end else if (ce) begin
      a_op    <= n_op;
      a_addr  <= n_addr;
      a_mask  <= n_mask;
      start_q <= n_start;
      beat_q  <= n_beat;
      b_op    <= a_op;
      b_addr  <= a_addr;
      b_mask  <= a_mask;
    end
  end

  // R1: a deselected load cycle captures no operation
  p_deselect_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !adv && !sel_ok) |=> (a_op == OP_IDLE));

  // R9: sleep turns every cycle into a deselect
  p_sleep_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && sleep) |=> (a_op == OP_IDLE));

  // R5: linear advance increments the low bits
  p_burst_lin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && adv && !sleep && linear) |=>
      (a_addr[1:0] == $past(a_addr[1:0]) + 2'd1));

  // R6: interleaved advance steps the XOR distance from the start
  p_burst_il_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && adv && !sleep && !linear) |=>
      ((a_addr[1:0] ^ start_q) == (($past(a_addr[1:0]) ^ $past(start_q)) + 2'd1)));

  // R7: a frozen edge moves no stage
  p_freeze_pipe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce) |=> ($stable(a_op) && $stable(a_addr) && $stable(b_op) && $stable(b_addr)));

endmodule

// File: rtl/zt_sram_core.sv
`timescale 1ns/1ps
// Storage array with a one-entry late-write buffer and read merge.
module zt_sram_core
  import zt_sram_pkg::*;
#(
  parameter int MEM_AW = 10,
  parameter int DW     = 36,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  op_e               b_op,
  input  logic [MEM_AW-1:0] b_idx,
  input  logic [LANES-1:0]  b_mask,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rd_word
);

  localparam int LW    = DW / LANES;
  localparam int DEPTH = 1 << MEM_AW;

  logic [DW-1:0]     mem [DEPTH];
  logic              wb_vld;
  logic [MEM_AW-1:0] wb_idx;
  logic [DW-1:0]     wb_data;
  logic [LANES-1:0]  wb_mask;

  logic              commit;
  logic              hit;
  logic [DW-1:0]     stored;

  assign commit = ce && (b_op == OP_WR);
  assign hit    = wb_vld && (wb_idx == b_idx);
  assign stored = mem[b_idx];

  // Retire the buffered write into the array when the next one arrives.
  always_ff @(posedge clk) begin
    if (commit && wb_vld) begin
      for (int k = 0; k < LANES; k++) begin
        if (wb_mask[k]) begin
          mem[wb_idx][k*LW +: LW] <= wb_data[k*LW +: LW];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_vld  <= 1'b0;
      wb_idx  <= '0;
      wb_data <= '0;
      wb_mask <= '0;
    end else if (commit) begin
      wb_vld  <= 1'b1;
      wb_idx  <= b_idx;
      wb_data <= wdata;
      wb_mask <= b_mask;
    end
  end

  // Lane-wise merge of the buffered write over the stored word.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_word[g*LW +: LW] = (hit && wb_mask[g]) ? wb_data[g*LW +: LW]
                                                     : stored[g*LW +: LW];
  end

  // R10: full-mask write followed at once by a read of the same word forwards it
  p_fwd_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && b_op == OP_WR && b_mask == '1) ##1 (b_op == OP_RD && b_idx == $past(b_idx))
      |-> (rd_word == $past(wdata)));

endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
// Top: pipelined synchronous SRAM with zero bus turnaround.
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int MEM_AW = 10,
  parameter int DW     = 36,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              sel_a_n_i,
  input  logic              sel_b_i,
  input  logic              sel_c_n_i,
  input  logic              adv_i,
  input  logic              clk_en_n_i,
  input  logic [LANES-1:0]  lane_we_n_i,
  input  logic              wr_n_i,
  input  logic              oe_n_i,
  input  logic              sleep_i,
  input  logic              burst_lin_i,
  output logic [DW-1:0]     dout_o,
  output logic              dout_drv_o
);

  logic              ce;
  logic              sel_ok;
  op_e               a_op;
  op_e               b_op;
  logic [ADDR_W-1:0] b_addr;
  logic [LANES-1:0]  b_mask;
  logic [DW-1:0]     rd_word;
  logic [DW-1:0]     out_q;
  logic              out_vld;
  logic              unused_hi;

  assign ce     = !clk_en_n_i;
  assign sel_ok = !sel_a_n_i && sel_b_i && !sel_c_n_i;

  zt_sram_ctrl #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (ce),
    .sel_ok    (sel_ok),
    .adv       (adv_i),
    .wr_n      (wr_n_i),
    .sleep     (sleep_i),
    .linear    (burst_lin_i),
    .addr      (addr_i),
    .lane_we_n (lane_we_n_i),
    .a_op      (a_op),
    .b_op      (b_op),
    .b_addr    (b_addr),
    .b_mask    (b_mask)
  );

  // Address bits above the array depth alias onto the reduced array.
  if (MEM_AW < ADDR_W) begin : g_alias
    assign unused_hi = ^b_addr[ADDR_W-1:MEM_AW];
  end else begin : g_full
    assign unused_hi = 1'b0;
  end

  zt_sram_core #(
    .MEM_AW (MEM_AW),
    .DW     (DW),
    .LANES  (LANES)
  ) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce      (ce),
    .b_op    (b_op),
    .b_idx   (b_addr[MEM_AW-1:0]),
    .b_mask  (b_mask),
    .wdata   (wdata_i),
    .rd_word (rd_word)
  );

  // Output register, loaded on the second enabled edge of a read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      out_vld <= 1'b0;
    end else if (ce) begin
      out_vld <= (b_op == OP_RD);
      if (b_op == OP_RD) begin
        out_q <= rd_word;
      end
    end
  end

  // Drivers gated without a clock by the output enable and sleep.
  assign dout_drv_o = out_vld && !oe_n_i && !sleep_i;
  assign dout_o     = dout_drv_o ? out_q : '0;

  // R2: a read in stage A reaches the output after two enabled edges
  p_rd_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && a_op == OP_RD) ##1 ce |=> out_vld);

  // R7: the output register holds through a frozen edge
  p_hold_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce) |=> ($stable(out_q) && $stable(out_vld)));

endmodule

// File: tb/zt_sram_tb.sv
`timescale 1ns/1ps
module zt_sram_tb;
  localparam int AW    = 19;
  localparam int MAW   = 6;
  localparam int DW    = 36;
  localparam int NL    = 4;
  localparam int DEPTH = 1 << MAW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [2:0]    sel_bits;
  logic          adv, clk_en_n, wr_n, oe_n, sleep, burst_lin;
  logic [NL-1:0] lane_we_n;
  logic [DW-1:0] dout;
  logic          dout_drv;

  zt_sram #(.ADDR_W(AW), .MEM_AW(MAW), .DW(DW), .LANES(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
    .sel_a_n_i(sel_bits[2]), .sel_b_i(sel_bits[1]), .sel_c_n_i(sel_bits[0]),
    .adv_i(adv), .clk_en_n_i(clk_en_n), .lane_we_n_i(lane_we_n), .wr_n_i(wr_n),
    .oe_n_i(oe_n), .sleep_i(sleep), .burst_lin_i(burst_lin),
    .dout_o(dout), .dout_drv_o(dout_drv)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Bench model: shadow memory, two issued slots, burst state.
  logic [DW-1:0] shadow [DEPTH];
  logic          exp_vld;
  logic [DW-1:0] exp_data;
  string         exp_tag;
  int            q1_op, q2_op;
  int            q1_addr, q2_addr;
  logic [NL-1:0] q1_mask, q2_mask;
  logic [DW-1:0] q1_wd, q2_wd;
  string         q1_tag, q2_tag;
  int            bb_addr, bb_step;
  int            salt;
  logic [2:0]    desel_pat;

  function automatic logic [DW-1:0] pat(int a, int s);
    return {4'(s), 26'(a * 4099 + s * 77 + 5), 6'(a)};
  endfunction

  task automatic check_out(string tag);
    logic          e_drv;
    logic [DW-1:0] e_out;
    e_drv = exp_vld && !oe_n && !sleep;
    e_out = e_drv ? exp_data : '0;
    n_chk++;
    if (dout_drv !== e_drv || dout !== e_out) begin
      n_fail++;
      $display("FAIL %s: drv=%0b dout=%h expected drv=%0b dout=%h",
               tag, dout_drv, dout, e_drv, e_out);
    end
  endtask

  // One clock: check outputs, drive next command, advance the model.
  task automatic step(bit ce, bit sel, bit ld, bit wr, int a, logic [NL-1:0] m, string tag);
    int nop;
    int naddr;
    @(negedge clk);
    check_out(exp_vld ? exp_tag : tag);
    clk_en_n  = !ce;
    sel_bits  = sel ? 3'b010 : desel_pat;
    adv       = !ld;
    wr_n      = !wr;
    addr      = AW'(a);
    lane_we_n = ~m;
    wdata     = {4'h0, $urandom};
    if (ce) begin
      if (q2_op == 2) begin
        wdata = q2_wd;
        for (int k = 0; k < NL; k++)
          if (q2_mask[k]) shadow[q2_addr][k*9 +: 9] = q2_wd[k*9 +: 9];
      end
      if (q2_op == 1) begin
        exp_vld  = 1'b1;
        exp_data = shadow[q2_addr];
        exp_tag  = q2_tag;
      end else begin
        exp_vld = 1'b0;
      end
      nop   = 0;
      naddr = q1_addr;
      if (sleep) begin
        nop = 0;
      end else if (ld) begin
        bb_addr = a;
        bb_step = 0;
        naddr   = a;
        if (sel_bits == 3'b010) nop = wr ? 2 : 1;
      end else begin
        bb_step = (bb_step + 1) % 4;
        naddr   = (bb_addr & ~3) |
                  (burst_lin ? ((bb_addr + bb_step) & 3) : ((bb_addr ^ bb_step) & 3));
        nop     = q1_op;
      end
      q2_op = q1_op; q2_addr = q1_addr; q2_mask = q1_mask; q2_wd = q1_wd; q2_tag = q1_tag;
      q1_op   = nop;
      q1_addr = naddr % DEPTH;
      q1_mask = m;
      q1_wd   = pat(naddr % DEPTH, salt);
      q1_tag  = tag;
    end
    @(posedge clk);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(1, 0, 1, 0, 0, 4'h0, tag);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; sel_bits = 3'b000; adv = 1'b0;
    clk_en_n = 1'b0; wr_n = 1'b1; oe_n = 1'b0; sleep = 1'b0; burst_lin = 1'b1;
    lane_we_n = '1; desel_pat = 3'b000; salt = 1;
    exp_vld = 1'b0; exp_data = '0; exp_tag = "";
    q1_op = 0; q2_op = 0; q1_addr = 0; q2_addr = 0; q1_mask = '0; q2_mask = '0;
    q1_wd = '0; q2_wd = '0; q1_tag = ""; q2_tag = ""; bb_addr = 0; bb_step = 0;
    for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_out("R11 reset drive off");
    rst_n = 1'b1;
    idle(3, "R11 idle after reset");

    // R3: back-to-back write sweep
    salt = 1;
    for (int a = 0; a < DEPTH; a++) step(1, 1, 1, 1, a, 4'hF, "R3 write sweep");
    // R2: back-to-back read sweep
    for (int a = 0; a < DEPTH; a++) step(1, 1, 1, 0, a, 4'h0, "R2 read sweep");
    idle(2, "R2 drain");

    // R4 / R10: partial-lane writes read back at once and interleaved
    salt = 2;
    for (int a = 0; a < 32; a++) begin
      step(1, 1, 1, 1, a, 4'(a % 16), "R4 lane write");
      step(1, 1, 1, 0, a, 4'h0, "R10 read of pending write");
      step(1, 1, 1, 0, a ^ 1, 4'h0, "R3 neighbour read");
    end
    idle(2, "R10 drain");

    // R5: linear burst writes checked by single reads, then a burst read
    burst_lin = 1'b1;
    for (int s = 0; s < 4; s++) begin
      salt = 3 + s;
      step(1, 1, 1, 1, 40 + s, 4'hF, "R5 linear burst write");
      for (int b = 0; b < 3; b++) step(1, 1, 0, 1, 0, 4'hF, "R5 linear burst write");
      idle(1, "R5 gap");
      for (int b = 0; b < 4; b++) step(1, 1, 1, 0, 40 + b, 4'h0, "R5 linear single read");
    end
    step(1, 1, 1, 0, 42, 4'h0, "R5 linear burst read");
    for (int b = 0; b < 3; b++) step(1, 1, 0, 0, 0, 4'h0, "R5 linear burst read");
    idle(2, "R5 drain");

    // R6: interleaved burst writes and reads
    burst_lin = 1'b0;
    for (int s = 0; s < 4; s++) begin
      salt = 8 + s;
      step(1, 1, 1, 1, 48 + s, 4'hF, "R6 interleaved burst write");
      for (int b = 0; b < 3; b++) step(1, 1, 0, 1, 0, 4'hF, "R6 interleaved burst write");
      idle(1, "R6 gap");
      for (int b = 0; b < 4; b++) step(1, 1, 1, 0, 48 + b, 4'h0, "R6 interleaved single read");
    end
    step(1, 1, 1, 0, 49, 4'h0, "R6 interleaved burst read");
    for (int b = 0; b < 3; b++) step(1, 1, 0, 0, 0, 4'h0, "R6 interleaved burst read");
    idle(2, "R6 drain");
    burst_lin = 1'b1;

    // R1: every bad chip-select combination, plus an advance after it
    salt = 12;
    for (int c = 0; c < 8; c++) begin
      if (c != 2) begin
        desel_pat = 3'(c);
        step(1, 0, 1, 1, 8 + c, 4'hF, "R1 deselected write");
        step(1, 0, 0, 1, 0, 4'hF, "R1 advance after deselect");
      end
    end
    desel_pat = 3'b000;
    idle(2, "R1 drain");
    for (int c = 0; c < 8; c++) step(1, 1, 1, 0, 8 + c, 4'h0, "R1 read after deselect");
    for (int c = 0; c < 4; c++) step(1, 1, 1, 0, 8 + c + 1, 4'h0, "R1 advance target read");
    idle(2, "R1 drain");

    // R7: freeze with a write's data slot pending and a read in flight
    salt = 13;
    step(1, 1, 1, 1, 6, 4'hF, "R7 write before freeze");
    step(1, 1, 1, 0, 5, 4'h0, "R7 read across freeze");
    for (int i = 0; i < 3; i++) step(0, 1, 1, 1, 5, 4'hF, "R7 frozen edge");
    idle(1, "R7 resume");
    for (int i = 0; i < 3; i++) step(0, 1, 1, 1, 7, 4'hF, "R7 frozen output hold");
    idle(2, "R7 resume");
    step(1, 1, 1, 0, 6, 4'h0, "R7 read of held write");
    step(1, 1, 1, 0, 5, 4'h0, "R7 read not overwritten");
    step(1, 1, 1, 0, 7, 4'h0, "R7 read not overwritten");
    idle(2, "R7 drain");

    // R8: output enable acts without a clock
    step(1, 1, 1, 0, 20, 4'h0, "R8 read");
    idle(2, "R8 read");
    #3; oe_n = 1'b1; #2;
    check_out("R8 output enable off");
    oe_n = 1'b0; #2;
    check_out("R8 output enable on");

    // R9: sleep drops drivers at once and blocks writes
    salt = 14;
    step(1, 1, 1, 0, 21, 4'h0, "R9 read");
    idle(2, "R9 read");
    #3; sleep = 1'b1; #2;
    check_out("R9 sleep drive off");
    step(1, 1, 1, 1, 21, 4'hF, "R9 write during sleep");
    step(1, 1, 0, 1, 0, 4'hF, "R9 advance during sleep");
    idle(2, "R9 sleep");
    sleep = 1'b0;
    step(1, 1, 1, 0, 21, 4'h0, "R9 contents kept");
    step(1, 1, 1, 0, 22, 4'h0, "R9 contents kept");
    idle(3, "R9 drain");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule